// File: doc/BRIEF.md
# Snooping Invalidation Coherence Controller

This block keeps one write-back cache coherent on a shared snooping bus. It holds a small direct-mapped array in which every entry has a tag, one 64-byte line register and a three-valued coherence state: Invalid, Shared or Exclusive. Shared means the line is a current copy that other caches may also hold. Exclusive means this cache holds the only correct copy and memory may be stale. The processor side presents one read, write or evict request at a time and holds it until the block reports completion. The bus side asks for a grant and then carries out one bus action per grant.

Other caches' read-miss and write-miss requests arrive on the snoop inputs. They are resolved in the cycle they appear. When a snoop finds an Exclusive copy, the block supplies the line on the snoop write-back outputs in that same cycle, before the line is downgraded or dropped. A line address is split with the set index in its low bits and the tag in the remaining upper bits.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every entry is Invalid, so the first read of any address is a miss and requests a bus read-miss.
- R2: A processor read whose set holds the same tag in Shared completes in that cycle with `cpu_hit`=1, no bus request, and the stored line on `cpu_rdata`.
- R3: A read miss, with no Exclusive line of another tag in the set, requests `bus_cmd`=1 (read-miss) at `bus_addr`=`cpu_addr`. On the grant cycle it completes with `cpu_hit`=0 and returns `bus_rdata`, and the entry becomes Shared with that data.
- R4: A write to a line that is not Exclusive (Shared with the same tag, or absent with no Exclusive victim) requests `bus_cmd`=2 (write-miss). On the grant cycle it completes, and the entry becomes Exclusive holding `cpu_wdata`.
- R5: When the line is Exclusive, processor reads and writes complete in the same cycle with `cpu_hit`=1 and no bus request. A write replaces the stored line.
- R6: A snooped read-miss (`snp_cmd`=1) that matches an Exclusive entry raises `snp_wb` in that cycle with the line data, and the entry becomes Shared.
- R7: A snooped write-miss (`snp_cmd`=2) that matches an entry makes it Invalid. If the entry was Exclusive, `snp_wb` carries the line in that cycle. If it was Shared, no write-back is made.
- R8: A snooped read-miss matching a Shared entry, any snoop whose tag does not match, and snoop codes 0 and 3 cause no write-back and leave the entry unchanged.
- R9: Evicting an Exclusive line requests `bus_cmd`=3 (write-back) with the line's address and data. It completes on the grant and leaves the entry Invalid. Evicting a Shared line, or an address that is absent, completes at once with `cpu_hit`=1 and no bus request, and a Shared line is dropped. Operation codes 2 and 3 both mean evict.
- R10: A read or write miss whose set holds a different tag in Exclusive first requests a write-back of that victim, at address {victim tag, set}. That grant does not complete the processor request. The entry becomes Invalid, and the miss request follows on a later cycle.
- R11: A bus request stays asserted until it is granted. While it waits, `cpu_done` stays low and the entry does not change.
- R12: A valid snoop to the same set as the pending processor request takes priority. In that cycle the processor request shows no bus request and does not complete, even if granted. The snoop is applied, and the request is evaluated again against the new state on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present; held until cpu_done |
| cpu_op | input | 2 | 0 read, 1 write, 2 or 3 evict |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_wdata | input | 8*LINE_BYTES | Line written by a write request |
| cpu_done | output | 1 | Request completes at this clock edge |
| cpu_hit | output | 1 | Completion without bus traffic |
| cpu_rdata | output | 8*LINE_BYTES | Read result, valid with cpu_done on a read |
| bus_req | output | 1 | Bus action wanted |
| bus_gnt | input | 1 | Arbitration grant for this cycle |
| bus_cmd | output | 2 | 0 idle, 1 read-miss, 2 write-miss, 3 write-back |
| bus_addr | output | ADDR_W | Line address of the bus action |
| bus_wdata | output | 8*LINE_BYTES | Line data for a write-back |
| bus_rdata | input | 8*LINE_BYTES | Memory data returned on a granted read-miss |
| snp_valid | input | 1 | Snooped request from another cache |
| snp_cmd | input | 2 | 1 read-miss, 2 write-miss, other codes ignored |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_wb | output | 1 | This cache supplies a forced write-back now |
| snp_wb_data | output | 8*LINE_BYTES | Line written back on a snoop |

## Verification
A wrong coherence state stays hidden until the next access to that line. It then shows as a wrong choice at the ports: a hit reported where a bus request belongs, the wrong bus command, a missing or extra write-back on a snoop, or stale data on a read. The bench therefore follows every state change with later reads, writes and snoops to the same set, usually within a few cycles. A wrong state is exposed on the first cycle the model and the block disagree on `cpu_hit`, `bus_cmd` or `snp_wb`. Tag/set aliasing is exercised deliberately with an address space four times the array, so victim write-backs and same-set snoop collisions occur often.

// File: rtl/coh_pkg.sv
package coh_pkg;

   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_EXC = 2'd2
   } lstate_e;

   typedef enum logic [1:0] {
      BC_IDLE   = 2'd0,
      BC_RDMISS = 2'd1,
      BC_WRMISS = 2'd2,
      BC_WBACK  = 2'd3
   } bcmd_e;

   localparam logic [1:0] OP_RD = 2'd0;
   localparam logic [1:0] OP_WR = 2'd1;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
   import coh_pkg::*;
#(
   parameter int NLINES = 4,
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 6,
   parameter int LINE_W = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   // snoop side: read port and state-only write port
   input  logic [IDX_W-1:0]  s_idx,
   output lstate_e           s_state_o,
   output logic [TAG_W-1:0]  s_tag_o,
   output logic [LINE_W-1:0] s_data_o,
   input  logic              s_we,
   input  lstate_e           s_state_i,
   // local side: read port and full write port
   input  logic [IDX_W-1:0]  l_idx,
   output lstate_e           l_state_o,
   output logic [TAG_W-1:0]  l_tag_o,
   output logic [LINE_W-1:0] l_data_o,
   input  logic              l_we,
   input  lstate_e           l_state_i,
   input  logic [TAG_W-1:0]  l_tag_i,
   input  logic              l_dwe,
   input  logic [LINE_W-1:0] l_data_i
);

   lstate_e           st_vec [NLINES];
   logic [TAG_W-1:0]  tg_vec [NLINES];
   logic [LINE_W-1:0] dt_vec [NLINES];

   for (genvar g = 0; g < NLINES; g++) begin : g_entry
      lstate_e           st_q;
      logic [TAG_W-1:0]  tg_q;
      logic [LINE_W-1:0] dt_q;
      logic              sel_s;
      logic              sel_l;

      assign sel_s = s_we && (s_idx == IDX_W'(g));
      assign sel_l = l_we && (l_idx == IDX_W'(g)) && !sel_s;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= LS_INV;
         end else if (sel_s) begin
            st_q <= s_state_i;
         end else if (sel_l) begin
            st_q <= l_state_i;
         end
      end

      always_ff @(posedge clk) begin
         if (sel_l) begin
            tg_q <= l_tag_i;
         end
         if (sel_l && l_dwe) begin
            dt_q <= l_data_i;
         end
      end

      assign st_vec[g] = st_q;
      assign tg_vec[g] = tg_q;
      assign dt_vec[g] = dt_q;
   end

   assign s_state_o = st_vec[s_idx];
   assign s_tag_o   = tg_vec[s_idx];
   assign s_data_o  = dt_vec[s_idx];
   assign l_state_o = st_vec[l_idx];
   assign l_tag_o   = tg_vec[l_idx];
   assign l_data_o  = dt_vec[l_idx];

endmodule

// File: rtl/coh_snoop_eval.sv
module coh_snoop_eval
   import coh_pkg::*;
#(
   parameter int TAG_W  = 6,
   parameter int LINE_W = 512
) (
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  lstate_e           line_state,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [LINE_W-1:0] line_data,
   output logic              upd_en,
   output lstate_e           upd_state,
   output logic              wb_valid,
   output logic [LINE_W-1:0] wb_data
);

   logic match;
   logic owned;

   assign match   = snp_valid && (line_state != LS_INV) && (line_tag == snp_tag);
   assign owned   = (line_state == LS_EXC);
   assign wb_data = line_data;

   always_comb begin
      upd_en    = 1'b0;
      upd_state = line_state;
      wb_valid  = 1'b0;
      if (match) begin
         case (snp_cmd)
            2'(BC_RDMISS): begin
               if (owned) begin
                  wb_valid  = 1'b1;
                  upd_en    = 1'b1;
                  upd_state = LS_SHR;
               end
            end
            2'(BC_WRMISS): begin
               wb_valid  = owned;
               upd_en    = 1'b1;
               upd_state = LS_INV;
            end
            default: begin
               upd_en = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/coh_req_eval.sv
module coh_req_eval
   import coh_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 6,
   parameter int LINE_W = 512
) (
   input  logic                   cpu_valid,
   input  logic [1:0]             cpu_op,
   input  logic [TAG_W-1:0]       cpu_tag,
   input  logic [IDX_W-1:0]       cpu_idx,
   input  logic [LINE_W-1:0]      cpu_wdata,
   input  logic                   blocked,
   input  logic                   bus_gnt,
   input  logic [LINE_W-1:0]      bus_rdata,
   input  lstate_e                line_state,
   input  logic [TAG_W-1:0]       line_tag,
   input  logic [LINE_W-1:0]      line_data,
   output logic                   bus_req,
   output bcmd_e                  bus_cmd,
   output logic [TAG_W+IDX_W-1:0] bus_addr,
   output logic [LINE_W-1:0]      bus_wdata,
   output logic                   cpu_done,
   output logic                   cpu_hit,
   output logic [LINE_W-1:0]      cpu_rdata,
   output logic                   upd_en,
   output lstate_e                upd_state,
   output logic [TAG_W-1:0]       upd_tag,
   output logic                   upd_dwe,
   output logic [LINE_W-1:0]      upd_data
);

   logic act;
   logic present;
   logic victim;
   logic need;
   bcmd_e cmd;

   assign act     = cpu_valid && !blocked;
   assign present = (line_state != LS_INV) && (line_tag == cpu_tag);
   assign victim  = (line_state == LS_EXC) && (line_tag != cpu_tag);

   assign bus_req   = need;
   assign bus_cmd   = need ? cmd : BC_IDLE;
   assign bus_addr  = (cmd == BC_WBACK) ? {line_tag, cpu_idx} : {cpu_tag, cpu_idx};
   assign bus_wdata = line_data;

   always_comb begin
      need      = 1'b0;
      cmd       = BC_IDLE;
      cpu_done  = 1'b0;
      cpu_hit   = 1'b0;
      cpu_rdata = line_data;
      upd_en    = 1'b0;
      upd_state = LS_INV;
      upd_tag   = line_tag;
      upd_dwe   = 1'b0;
      upd_data  = cpu_wdata;
      if (act) begin
         case (cpu_op)
            OP_RD: begin
               if (present) begin
                  cpu_done = 1'b1;
                  cpu_hit  = 1'b1;
               end else if (victim) begin
                  need = 1'b1;
                  cmd  = BC_WBACK;
               end else begin
                  need = 1'b1;
                  cmd  = BC_RDMISS;
               end
            end
            OP_WR: begin
               if (present && line_state == LS_EXC) begin
                  cpu_done  = 1'b1;
                  cpu_hit   = 1'b1;
                  upd_en    = 1'b1;
                  upd_state = LS_EXC;
                  upd_dwe   = 1'b1;
               end else if (victim) begin
                  need = 1'b1;
                  cmd  = BC_WBACK;
               end else begin
                  need = 1'b1;
                  cmd  = BC_WRMISS;
               end
            end
            default: begin
               if (present && line_state == LS_EXC) begin
                  need = 1'b1;
                  cmd  = BC_WBACK;
               end else begin
                  cpu_done = 1'b1;
                  cpu_hit  = 1'b1;
                  upd_en   = present;
               end
            end
         endcase

         if (need && bus_gnt) begin
            case (cmd)
               BC_RDMISS: begin
                  cpu_done  = 1'b1;
                  cpu_rdata = bus_rdata;
                  upd_en    = 1'b1;
                  upd_state = LS_SHR;
                  upd_tag   = cpu_tag;
                  upd_dwe   = 1'b1;
                  upd_data  = bus_rdata;
               end
               BC_WRMISS: begin
                  cpu_done  = 1'b1;
                  upd_en    = 1'b1;
                  upd_state = LS_EXC;
                  upd_tag   = cpu_tag;
                  upd_dwe   = 1'b1;
               end
               default: begin
                  // write-back: own eviction completes, victim clearing does not
                  cpu_done  = cpu_op[1];
                  upd_en    = 1'b1;
                  upd_state = LS_INV;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
   import coh_pkg::*;
#(
   parameter int NLINES     = 4,
   parameter int ADDR_W     = 8,
   parameter int LINE_BYTES = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_valid,
   input  logic [1:0]              cpu_op,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [8*LINE_BYTES-1:0] cpu_wdata,
   output logic                    cpu_done,
   output logic                    cpu_hit,
   output logic [8*LINE_BYTES-1:0] cpu_rdata,
   output logic                    bus_req,
   input  logic                    bus_gnt,
   output logic [1:0]              bus_cmd,
   output logic [ADDR_W-1:0]       bus_addr,
   output logic [8*LINE_BYTES-1:0] bus_wdata,
   input  logic [8*LINE_BYTES-1:0] bus_rdata,
   input  logic                    snp_valid,
   input  logic [1:0]              snp_cmd,
   input  logic [ADDR_W-1:0]       snp_addr,
   output logic                    snp_wb,
   output logic [8*LINE_BYTES-1:0] snp_wb_data
);

   localparam int IDX_W  = (NLINES > 1) ? $clog2(NLINES) : 1;
   localparam int TAG_W  = ADDR_W - IDX_W;
   localparam int LINE_W = 8 * LINE_BYTES;

   if (NLINES < 2 || (NLINES & (NLINES - 1)) != 0) begin : g_chk_lines
      $error("coh_line_ctrl: NLINES must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_chk_addr
      $error("coh_line_ctrl: ADDR_W must leave at least one tag bit");
   end
   if (LINE_BYTES < 1) begin : g_chk_line
      $error("coh_line_ctrl: LINE_BYTES must be positive");
   end

   logic [IDX_W-1:0]  c_idx;
   logic [TAG_W-1:0]  c_tag;
   logic [IDX_W-1:0]  s_idx;
   logic [TAG_W-1:0]  s_tag;
   logic              same_set_block;

   assign c_idx = cpu_addr[IDX_W-1:0];
   assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign s_idx = snp_addr[IDX_W-1:0];
   assign s_tag = snp_addr[ADDR_W-1:IDX_W];

   // snoop owns the set in a cycle where both sides address it
   assign same_set_block = snp_valid && (s_idx == c_idx);

   lstate_e           sl_state;
   logic [TAG_W-1:0]  sl_tag;
   logic [LINE_W-1:0] sl_data;
   logic              s_we;
   lstate_e           s_state_n;

   lstate_e           ll_state;
   logic [TAG_W-1:0]  ll_tag;
   logic [LINE_W-1:0] ll_data;
   logic              l_we;
   lstate_e           l_state_n;
   logic [TAG_W-1:0]  l_tag_n;
   logic              l_dwe;
   logic [LINE_W-1:0] l_data_n;
   bcmd_e             cmd_e;

   coh_line_store #(
      .NLINES (NLINES),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .LINE_W (LINE_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_idx     (s_idx),
      .s_state_o (sl_state),
      .s_tag_o   (sl_tag),
      .s_data_o  (sl_data),
      .s_we      (s_we),
      .s_state_i (s_state_n),
      .l_idx     (c_idx),
      .l_state_o (ll_state),
      .l_tag_o   (ll_tag),
      .l_data_o  (ll_data),
      .l_we      (l_we),
      .l_state_i (l_state_n),
      .l_tag_i   (l_tag_n),
      .l_dwe     (l_dwe),
      .l_data_i  (l_data_n)
   );

   coh_snoop_eval #(
      .TAG_W  (TAG_W),
      .LINE_W (LINE_W)
   ) u_snoop (
      .snp_valid  (snp_valid),
      .snp_cmd    (snp_cmd),
      .snp_tag    (s_tag),
      .line_state (sl_state),
      .line_tag   (sl_tag),
      .line_data  (sl_data),
      .upd_en     (s_we),
      .upd_state  (s_state_n),
      .wb_valid   (snp_wb),
      .wb_data    (snp_wb_data)
   );

   coh_req_eval #(
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .LINE_W (LINE_W)
   ) u_req (
      .cpu_valid  (cpu_valid),
      .cpu_op     (cpu_op),
      .cpu_tag    (c_tag),
      .cpu_idx    (c_idx),
      .cpu_wdata  (cpu_wdata),
      .blocked    (same_set_block),
      .bus_gnt    (bus_gnt),
      .bus_rdata  (bus_rdata),
      .line_state (ll_state),
      .line_tag   (ll_tag),
      .line_data  (ll_data),
      .bus_req    (bus_req),
      .bus_cmd    (cmd_e),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .cpu_done   (cpu_done),
      .cpu_hit    (cpu_hit),
      .cpu_rdata  (cpu_rdata),
      .upd_en     (l_we),
      .upd_state  (l_state_n),
      .upd_tag    (l_tag_n),
      .upd_dwe    (l_dwe),
      .upd_data   (l_data_n)
   );

   assign bus_cmd = cmd_e;

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
   parameter int NLINES = 4,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_valid,
   input logic [1:0]        cpu_op,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_done,
   input logic              cpu_hit,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic [1:0]        bus_cmd,
   input logic              snp_valid,
   input logic [1:0]        snp_cmd,
   input logic [ADDR_W-1:0] snp_addr,
   input logic              snp_wb
);

   localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1;

   AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> cpu_valid); // R11

   AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hit |-> (cpu_done && !bus_req)); // R2

   AST_MISS_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && !cpu_hit) |-> (bus_req && bus_gnt)); // R3

   AST_SAME_SET_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && cpu_valid && snp_addr[IW-1:0] == cpu_addr[IW-1:0])
         |-> (!bus_req && !cpu_done)); // R12

   AST_WB_ONLY_MISS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      snp_wb |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2))); // R8

   AST_NO_REPEAT_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && $past(snp_wb) && $past(snp_addr) == snp_addr) |-> !snp_wb); // R7

   AST_EVICT_WB_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && !cpu_hit && cpu_op[1]) |-> (bus_gnt && bus_cmd == 2'd3)); // R9

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(
   .NLINES (NLINES),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_valid (cpu_valid),
   .cpu_op    (cpu_op),
   .cpu_addr  (cpu_addr),
   .cpu_done  (cpu_done),
   .cpu_hit   (cpu_hit),
   .bus_req   (bus_req),
   .bus_gnt   (bus_gnt),
   .bus_cmd   (bus_cmd),
   .snp_valid (snp_valid),
   .snp_cmd   (snp_cmd),
   .snp_addr  (snp_addr),
   .snp_wb    (snp_wb)
);

// File: tb/coh_line_ctrl_tb.sv
module coh_line_ctrl_tb;

   localparam int NL = 4;
   localparam int AW = 8;
   localparam int LB = 64;
   localparam int LW = 8 * LB;
   localparam int IW = 2;
   localparam int TW = AW - IW;
   localparam int RAND_CYCLES = 4000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_valid = 1'b0;
   logic [1:0]    cpu_op = 2'd0;
   logic [AW-1:0] cpu_addr = '0;
   logic [LW-1:0] cpu_wdata = '0;
   logic          cpu_done;
   logic          cpu_hit;
   logic [LW-1:0] cpu_rdata;
   logic          bus_req;
   logic          bus_gnt = 1'b0;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [LW-1:0] bus_wdata;
   logic [LW-1:0] bus_rdata = '0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = 2'd0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_wb;
   logic [LW-1:0] snp_wb_data;

   always #5 clk = ~clk;

   coh_line_ctrl #(.NLINES(NL), .ADDR_W(AW), .LINE_BYTES(LB)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_wb(snp_wb), .snp_wb_data(snp_wb_data)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference model: 0 Invalid, 1 Shared, 2 Exclusive
   logic [1:0]    m_st  [NL];
   logic [TW-1:0] m_tag [NL];
   logic [LW-1:0] m_dat [NL];

   logic          e_req, e_done, e_hit, e_swb;
   logic [1:0]    e_cmd;
   logic [AW-1:0] e_addr;
   logic [LW-1:0] e_wdat, e_rdat, e_swbd;
   logic          e_upd, e_udw, s_upd;
   logic [1:0]    e_ust, s_ust;
   logic [TW-1:0] e_utag;
   logic [LW-1:0] e_udata;
   int            e_ci, e_si;
   string         c_tag, s_tag;

   function automatic logic [LW-1:0] rand_line();
      logic [LW-1:0] v;
      for (int k = 0; k < LW / 32; k++) v[k*32 +: 32] = $urandom();
      return v;
   endfunction

   task automatic chk(string rq, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic model_eval();
      logic [TW-1:0] ct, st;
      logic blk, present, victim, need, smatch;
      e_ci = int'(cpu_addr[IW-1:0]);
      e_si = int'(snp_addr[IW-1:0]);
      ct = cpu_addr[AW-1:IW];
      st = snp_addr[AW-1:IW];
      e_req = 0; e_done = 0; e_hit = 0; e_cmd = 0; e_upd = 0; e_udw = 0;
      e_ust = 0; e_utag = m_tag[e_ci]; e_udata = cpu_wdata;
      e_addr = cpu_addr; e_wdat = m_dat[e_ci]; e_rdat = m_dat[e_ci];
      c_tag = "R11"; need = 0;
      blk = snp_valid && (snp_addr[IW-1:0] == cpu_addr[IW-1:0]);
      present = (m_st[e_ci] != 0) && (m_tag[e_ci] == ct);
      victim = (m_st[e_ci] == 2) && (m_tag[e_ci] != ct);
      if (cpu_valid && blk) begin
         c_tag = "R12";
      end else if (cpu_valid) begin
         if (cpu_op == 0) begin
            if (present) begin
               e_done = 1; e_hit = 1; c_tag = (m_st[e_ci] == 2) ? "R5" : "R2";
            end else if (victim) begin
               need = 1; e_cmd = 3; c_tag = "R10";
            end else begin
               need = 1; e_cmd = 1; c_tag = "R3";
            end
         end else if (cpu_op == 1) begin
            if (present && m_st[e_ci] == 2) begin
               e_done = 1; e_hit = 1; e_upd = 1; e_ust = 2; e_utag = ct; e_udw = 1;
               c_tag = "R5";
            end else if (victim) begin
               need = 1; e_cmd = 3; c_tag = "R10";
            end else begin
               need = 1; e_cmd = 2; c_tag = "R4";
            end
         end else begin
            c_tag = "R9";
            if (present && m_st[e_ci] == 2) begin
               need = 1; e_cmd = 3;
            end else begin
               e_done = 1; e_hit = 1; e_upd = present; e_ust = 0;
            end
         end
         e_req = need;
         if (e_cmd == 3) e_addr = {m_tag[e_ci], cpu_addr[IW-1:0]};
         if (need && bus_gnt) begin
            if (e_cmd == 1) begin
               e_done = 1; e_rdat = bus_rdata; e_upd = 1; e_ust = 1; e_utag = ct;
               e_udw = 1; e_udata = bus_rdata;
            end else if (e_cmd == 2) begin
               e_done = 1; e_upd = 1; e_ust = 2; e_utag = ct; e_udw = 1;
            end else begin
               e_done = cpu_op[1]; e_upd = 1; e_ust = 0;
            end
         end
      end
      // snoop side
      e_swb = 0; s_upd = 0; s_ust = m_st[e_si]; e_swbd = m_dat[e_si]; s_tag = "R8";
      smatch = snp_valid && (m_st[e_si] != 0) && (m_tag[e_si] == st);
      if (smatch && snp_cmd == 1 && m_st[e_si] == 2) begin
         e_swb = 1; s_upd = 1; s_ust = 1; s_tag = "R6";
      end else if (smatch && snp_cmd == 2) begin
         e_swb = (m_st[e_si] == 2); s_upd = 1; s_ust = 0; s_tag = "R7";
      end
   endtask

   task automatic compare_all();
      chk(c_tag, "bus_req", LW'(bus_req), LW'(e_req));
      chk(c_tag, "cpu_done", LW'(cpu_done), LW'(e_done));
      chk(c_tag, "cpu_hit", LW'(cpu_hit), LW'(e_hit));
      if (e_req) begin
         chk(c_tag, "bus_cmd", LW'(bus_cmd), LW'(e_cmd));
         chk(c_tag, "bus_addr", LW'(bus_addr), LW'(e_addr));
         if (e_cmd == 3) chk(c_tag, "bus_wdata", bus_wdata, e_wdat);
      end
      if (e_done && cpu_op == 0) chk(c_tag, "cpu_rdata", cpu_rdata, e_rdat);
      chk(s_tag, "snp_wb", LW'(snp_wb), LW'(e_swb));
      if (e_swb) chk(s_tag, "snp_wb_data", snp_wb_data, e_swbd);
   endtask

   // called just after a negedge with inputs driven; returns at the next negedge
   task automatic step();
      #1;
      model_eval();
      compare_all();
      @(posedge clk);
      if (s_upd) m_st[e_si] = s_ust;
      if (e_upd) begin
         m_st[e_ci] = e_ust;
         m_tag[e_ci] = e_utag;
         if (e_udw) m_dat[e_ci] = e_udata;
      end
      @(negedge clk);
   endtask

   task automatic drive(logic cv, logic [1:0] op, logic [AW-1:0] a, logic sv,
                        logic [1:0] sc, logic [AW-1:0] sa, logic g);
      cpu_valid = cv; cpu_op = op; cpu_addr = a; cpu_wdata = rand_line();
      snp_valid = sv; snp_cmd = sc; snp_addr = sa; bus_gnt = g; bus_rdata = rand_line();
   endtask

   // one processor request to completion with grant on the second request cycle
   task automatic cpu_txn(logic [1:0] op, logic [AW-1:0] a);
      logic [LW-1:0] wd;
      int guard;
      wd = rand_line();
      guard = 0;
      drive(1, op, a, 0, 0, 0, 0);
      cpu_wdata = wd;
      step();
      while (!e_done && guard < 8) begin
         drive(1, op, a, 0, 0, 0, 1);
         cpu_wdata = wd;
         step();
         guard++;
      end
      drive(0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic snoop(logic [1:0] sc, logic [AW-1:0] sa);
      drive(0, 0, 0, 1, sc, sa, 0);
      step();
      drive(0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < NL; i++) begin
         m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
      end
      repeat (3) @(negedge clk);
      #1;
      // R1: outputs quiet during reset
      chk("R1", "bus_req in reset", LW'(bus_req), '0);
      chk("R1", "snp_wb in reset", LW'(snp_wb), '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: first read after reset misses
      drive(1, 0, 8'h05, 0, 0, 0, 0);
      #1;
      chk("R1", "bus_cmd first read", LW'(bus_cmd), LW'(2'd1));
      chk("R1", "cpu_hit first read", LW'(cpu_hit), '0);
      @(negedge clk);
      cpu_txn(0, 8'h05);           // R11 wait then R3 fill
      cpu_txn(0, 8'h05);           // R2 shared hit
      cpu_txn(1, 8'h05);           // R4 write-miss from Shared
      cpu_txn(0, 8'h05);           // R5 exclusive read
      cpu_txn(1, 8'h05);           // R5 exclusive write
      snoop(1, 8'h05);             // R6 forced write-back, to Shared
      cpu_txn(1, 8'h05);           // R4 again after downgrade
      snoop(2, 8'h05);             // R7 write-back and invalidate
      cpu_txn(0, 8'h05);           // R3 refill
      snoop(2, 8'h05);             // R7 shared invalidate, no write-back
      cpu_txn(1, 8'h09);           // R4 into set 1, tag 2
      snoop(1, 8'h0D);             // R8 tag miss
      snoop(0, 8'h09);             // R8 idle code
      snoop(3, 8'h09);             // R8 reserved code
      cpu_txn(0, 8'h09);           // R5 still exclusive
      cpu_txn(0, 8'h05);           // R10 victim write-back then R3
      cpu_txn(1, 8'h05);           // R4
      cpu_txn(2, 8'h05);           // R9 evict exclusive
      cpu_txn(3, 8'h21);           // R9 evict absent
      cpu_txn(0, 8'h05);           // R3 miss after eviction
      cpu_txn(2, 8'h05);           // R9 evict shared
      cpu_txn(1, 8'h06);           // R4 set 2
      // R12: read same set as a granted snoop write-miss
      drive(1, 0, 8'h06, 1, 2, 8'h06, 1);
      step();
      chk("R12", "blocked done", LW'(cpu_done), '0);
      drive(1, 0, 8'h06, 0, 0, 0, 0);
      step();
      chk("R12", "re-evaluated as miss", LW'(bus_cmd), LW'(2'd1));
      cpu_txn(0, 8'h06);

      // constrained random interleaving
      begin
         logic          pend;
         logic [1:0]    op;
         logic [AW-1:0] a;
         logic [LW-1:0] wd;
         pend = 0; op = 0; a = 0; wd = '0;
         for (int c = 0; c < RAND_CYCLES; c++) begin
            if (!pend && ($urandom() % 10) < 7) begin
               pend = 1;
               op = 2'($urandom() % 4);
               a = AW'($urandom() % 16);
               wd = rand_line();
            end
            drive(pend, op, a, ($urandom() % 10) < 3, 2'($urandom() % 4),
                  AW'($urandom() % 16), ($urandom() % 2) == 0);
            cpu_wdata = wd;
            step();
            if (e_done) pend = 0;
         end
         drive(0, 0, 0, 0, 0, 0, 0);
      end

      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!finished) begin
         finished = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule